// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic core of a 32-bit integer datapath. It takes two operands that are already fetched and shifted. It also takes a 4-bit operation code, a request to update the flags, the index of the destination register, the current carry flag and the carry-out of the operand shifter. From these it computes, within the same cycle, the result word and whether that word is written back. It also produces candidate values for the negative, zero, carry and overflow flags, each with its own update enable.

The block holds no state. The caller registers the result and applies each flag value only when that flag's enable is high. The sixteen operations fall into three groups:

- Bitwise operations, which take their carry flag from the shifter.
- Add/subtract operations, including the reversed-operand forms.
- Compare/test operations, which update flags but never write a register.

Top module: `dp_alu`

## Requirements
- R1: Opcode values are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. The results of the bitwise group are: AND a&b, EOR a^b, ORR a|b, MOV b, BIC a&~b, MVN ~b. TST and TEQ present a&b and a^b on the result port.
- R2: ADD and CMN produce a+b modulo 2^32. Their carry is the carry-out of bit 31, and their overflow is bit 31 of (a^r)&(b^r).
- R3: ADC produces a+b+carry_in. Its carry is set if either the addition of a and b or the addition of the old carry overflows 32 bits.
- R4: SUB and CMP produce a-b. Their carry is set exactly when b <= a as unsigned values, and their overflow is bit 31 of (a^r)&(~b^r).
- R5: SBC produces a-(b-carry_in+1), with the subtrahend formed in 33 bits. Its carry is set exactly when that subtrahend is <= a, and its overflow is bit 31 of (a^r)&(~b^r).
- R6: RSB and RSC behave as SUB and SBC with the two operands exchanged.
- R7: For the bitwise group (opcodes 0, 1, 8, 9, 12-15), the carry value equals shift_carry and upd_v is never asserted.
- R8: wr_en is 0 for opcodes 8 to 11 and 1 for every other opcode, whatever set_flags and dest_idx are.
- R9: For opcodes outside 8 to 11, all four flag enables are 0 unless set_flags is 1 and dest_idx is not 15. When enabled, bitwise operations assert upd_n, upd_z and upd_c, and add/subtract operations assert all four.
- R10: TST and TEQ assert upd_n, upd_z and upd_c but not upd_v. CMP and CMN assert all four. This holds regardless of set_flags and dest_idx.
- R11: Whenever a flag is enabled, the negative value is result bit 31 and the zero value is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second (shifted) operand |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Flag update requested by the instruction |
| dest_idx | input | 4 | Destination register index |
| carry_in | input | 1 | Current carry flag |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| flag_n | output | 1 | Candidate negative flag |
| flag_z | output | 1 | Candidate zero flag |
| flag_c | output | 1 | Candidate carry flag |
| flag_v | output | 1 | Candidate overflow flag |
| upd_n | output | 1 | Negative flag update enable |
| upd_z | output | 1 | Zero flag update enable |
| upd_c | output | 1 | Carry flag update enable |
| upd_v | output | 1 | Overflow flag update enable |

## Verification
The bench builds the block with its default width of 32. At this width, the model's 33-bit arithmetic reaches the carry and overflow boundaries directly. The directed vectors use all-ones, sign-bit-only and equal operands. They cover the subtrahend wrapping to 2^32 in the borrow-subtract and a carry that arises only from adding the old carry. Random vectors sweep every opcode with set_flags and the destination index varied, including index 15, so the flag gating is exercised for each operation group.

// File: rtl/dpalu_pkg.sv
`timescale 1ns/1ps
package dpalu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;

  typedef enum logic [1:0] {LF_AND, LF_EOR, LF_ORR, LF_PASS} logic_fn_e;

  typedef struct packed {
    logic      is_arith;
    logic      is_test;
    logic      swap;
    logic      inv_b;
    cin_sel_e  cin;
    logic_fn_e lfn;
  } alu_dec_t;

  localparam logic [3:0] PC_INDEX = 4'd15;

endpackage

// File: rtl/dpalu_decode.sv
`timescale 1ns/1ps
module dpalu_decode
  import dpalu_pkg::*;
(
  input  logic [3:0] opcode,
  output alu_dec_t   dec
);

  alu_op_e op;
  assign op = alu_op_e'(opcode);

  always_comb begin
    dec = '{is_arith: 1'b0, is_test: 1'b0, swap: 1'b0, inv_b: 1'b0,
            cin: CIN_ZERO, lfn: LF_AND};
    unique case (op)
      OP_AND: dec.lfn = LF_AND;
      OP_EOR: dec.lfn = LF_EOR;
      OP_ORR: dec.lfn = LF_ORR;
      OP_MOV: dec.lfn = LF_PASS;
      OP_BIC: begin dec.lfn = LF_AND;  dec.inv_b = 1'b1; end
      OP_MVN: begin dec.lfn = LF_PASS; dec.inv_b = 1'b1; end
      OP_TST: begin dec.lfn = LF_AND;  dec.is_test = 1'b1; end
      OP_TEQ: begin dec.lfn = LF_EOR;  dec.is_test = 1'b1; end
      OP_ADD: dec.is_arith = 1'b1;
      OP_CMN: begin dec.is_arith = 1'b1; dec.is_test = 1'b1; end
      OP_ADC: begin dec.is_arith = 1'b1; dec.cin = CIN_FLAG; end
      OP_SUB: begin dec.is_arith = 1'b1; dec.inv_b = 1'b1; dec.cin = CIN_ONE; end
      OP_CMP: begin dec.is_arith = 1'b1; dec.inv_b = 1'b1; dec.cin = CIN_ONE;
                    dec.is_test = 1'b1; end
      OP_RSB: begin dec.is_arith = 1'b1; dec.inv_b = 1'b1; dec.cin = CIN_ONE;
                    dec.swap = 1'b1; end
      OP_SBC: begin dec.is_arith = 1'b1; dec.inv_b = 1'b1; dec.cin = CIN_FLAG; end
      OP_RSC: begin dec.is_arith = 1'b1; dec.inv_b = 1'b1; dec.cin = CIN_FLAG;
                    dec.swap = 1'b1; end
      default: dec.lfn = LF_AND;
    endcase
  end

endmodule

// File: rtl/dpalu_adder.sv
`timescale 1ns/1ps
module dpalu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[WIDTH];
    ovf  = (x[MSB] ^ sum[MSB]) & (y[MSB] ^ sum[MSB]);
  end

endmodule

// File: rtl/dpalu_logic.sv
`timescale 1ns/1ps
module dpalu_logic
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] out
);

  always_comb begin
    unique case (fn)
      LF_AND:  out = x & y;
      LF_EOR:  out = x ^ y;
      LF_ORR:  out = x | y;
      default: out = y;
    endcase
  end

endmodule

// File: rtl/dpalu_flags.sv
`timescale 1ns/1ps
module dpalu_flags
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_dec_t         dec,
  input  logic [WIDTH-1:0] res,
  input  logic             add_cout,
  input  logic             add_ovf,
  input  logic             shift_carry,
  input  logic             set_flags,
  input  logic [3:0]       dest_idx,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v,
  output logic             upd_n,
  output logic             upd_z,
  output logic             upd_c,
  output logic             upd_v
);

  logic gate;

  always_comb begin
    gate   = dec.is_test | (set_flags & (dest_idx != PC_INDEX));
    flag_n = res[WIDTH-1];
    flag_z = (res == '0);
    flag_c = dec.is_arith ? add_cout : shift_carry;
    flag_v = add_ovf;
    upd_n  = gate;
    upd_z  = gate;
    upd_c  = gate;
    upd_v  = gate & dec.is_arith;
  end

endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic [3:0]       dest_idx,
  input  logic             carry_in,
  input  logic             shift_carry,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v,
  output logic             upd_n,
  output logic             upd_z,
  output logic             upd_c,
  output logic             upd_v
);

  alu_dec_t         dec;
  logic [WIDTH-1:0] x_opnd, y_raw, y_opnd;
  logic [WIDTH-1:0] sum, lres;
  logic             cin_bit, cout, ovf;

  dpalu_decode u_dec (.opcode(opcode), .dec(dec));

  always_comb begin
    x_opnd = dec.swap ? op_b : op_a;
    y_raw  = dec.swap ? op_a : op_b;
    y_opnd = dec.inv_b ? ~y_raw : y_raw;
    unique case (dec.cin)
      CIN_ONE:  cin_bit = 1'b1;
      CIN_FLAG: cin_bit = carry_in;
      default:  cin_bit = 1'b0;
    endcase
  end

  dpalu_adder #(.WIDTH(WIDTH)) u_add (
    .x(x_opnd), .y(y_opnd), .cin(cin_bit),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  dpalu_logic #(.WIDTH(WIDTH)) u_log (
    .x(x_opnd), .y(y_opnd), .fn(dec.lfn), .out(lres)
  );

  assign result = dec.is_arith ? sum : lres;
  assign wr_en  = ~dec.is_test;

  dpalu_flags #(.WIDTH(WIDTH)) u_flg (
    .dec(dec), .res(result), .add_cout(cout), .add_ovf(ovf),
    .shift_carry(shift_carry), .set_flags(set_flags), .dest_idx(dest_idx),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .upd_n(upd_n), .upd_z(upd_z), .upd_c(upd_c), .upd_v(upd_v)
  );

  always_comb begin
    p_v_kept_r7: assert (dec.is_arith || !upd_v)
      else $error("overflow enable on a bitwise op");
    p_shift_c_r7: assert (dec.is_arith || !upd_c || flag_c == shift_carry)
      else $error("bitwise carry not from shifter");
    p_gate_r9: assert (!wr_en || set_flags && dest_idx != 4'd15
                       || !(upd_n || upd_z || upd_c || upd_v))
      else $error("flags enabled without request");
    p_test_r10: assert (wr_en || (upd_n && upd_z && upd_c))
      else $error("compare op without flag update");
    p_zero_r11: assert (!upd_z || (flag_z == (result == '0)))
      else $error("zero flag disagrees with result");
    p_add_r2: assert (opcode != 4'h4 || result == op_a + op_b)
      else $error("add result wrong");
  end

endmodule

// File: tb/tb_dp_alu.sv
`timescale 1ns/1ps
module tb_dp_alu;

  logic        clk = 1'b0;
  logic [31:0] op_a, op_b, result;
  logic [3:0]  opcode, dest_idx;
  logic        set_flags, carry_in, shift_carry, wr_en;
  logic        flag_n, flag_z, flag_c, flag_v, upd_n, upd_z, upd_c, upd_v;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dp_alu dut (
    .op_a(op_a), .op_b(op_b), .opcode(opcode), .set_flags(set_flags),
    .dest_idx(dest_idx), .carry_in(carry_in), .shift_carry(shift_carry),
    .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .upd_n(upd_n), .upd_z(upd_z),
    .upd_c(upd_c), .upd_v(upd_v)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s op=%h: got %h expected %h", tag, what, opcode, got, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic s, logic [3:0] d, logic c, logic sc);
    logic [32:0] wide, subtr;
    logic [31:0] r, xa, yb;
    logic        ec, ev, arith, test, gate, en_nzc, en_v;
    string       rtag, ctag;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; set_flags = s;
    dest_idx = d; carry_in = c; shift_carry = sc;
    test  = (op >= 4'h8 && op <= 4'hB);
    arith = (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
    ec = sc; ev = 1'b0; r = '0;
    xa = (op == 4'h3 || op == 4'h7) ? b : a;
    yb = (op == 4'h3 || op == 4'h7) ? a : b;
    case (op)
      4'h0, 4'h8: begin r = a & b;  rtag = "R1"; end
      4'h1, 4'h9: begin r = a ^ b;  rtag = "R1"; end
      4'hC: begin r = a | b;  rtag = "R1"; end
      4'hD: begin r = b;      rtag = "R1"; end
      4'hE: begin r = a & ~b; rtag = "R1"; end
      4'hF: begin r = ~b;     rtag = "R1"; end
      4'h4, 4'hB, 4'h5: begin
        wide = {1'b0, a} + {1'b0, b};
        ec   = wide[32];
        if (op == 4'h5) begin
          wide = {1'b0, wide[31:0]} + {32'd0, c};
          ec   = ec | wide[32];
        end
        r  = wide[31:0];
        ev = (a[31] ^ r[31]) & (b[31] ^ r[31]);
        rtag = (op == 4'h5) ? "R3" : "R2";
      end
      default: begin
        if (op == 4'h2 || op == 4'h3 || op == 4'hA) subtr = {1'b0, yb};
        else subtr = {1'b0, yb} + 33'd1 - {32'd0, c};
        r  = xa - subtr[31:0];
        ec = (subtr <= {1'b0, xa});
        ev = (xa[31] ^ r[31]) & (~yb[31] ^ r[31]);
        rtag = (op == 4'h3 || op == 4'h7) ? "R6" : (op == 4'h6 ? "R5" : "R4");
      end
    endcase
    gate   = test || (s && d != 4'd15);
    en_nzc = gate;
    en_v   = gate && arith;
    ctag   = arith ? rtag : "R7";
    @(posedge clk); #1;
    chk(rtag, "result", result, r);
    chk("R8", "wr_en", {31'd0, wr_en}, {31'd0, !test});
    chk(test ? "R10" : "R9", "enables", {28'd0, upd_n, upd_z, upd_c, upd_v},
        {28'd0, en_nzc, en_nzc, en_nzc, en_v});
    if (en_nzc) begin
      chk("R11", "flag_n", {31'd0, flag_n}, {31'd0, r[31]});
      chk("R11", "flag_z", {31'd0, flag_z}, {31'd0, r == 32'd0});
      chk(ctag, "flag_c", {31'd0, flag_c}, {31'd0, ec});
    end
    if (en_v) chk(rtag, "flag_v", {31'd0, flag_v}, {31'd0, ev});
    if (!arith) chk("R7", "upd_v", {31'd0, upd_v}, 32'd0);
  endtask

  initial begin
    op_a = '0; op_b = '0; opcode = '0; set_flags = 1'b0;
    dest_idx = '0; carry_in = 1'b0; shift_carry = 1'b0;
    @(posedge clk); #1;
    chk("R1", "idle result", result, 32'd0);
    chk("R9", "idle enables", {28'd0, upd_n, upd_z, upd_c, upd_v}, 32'd0);
    apply(4'h4, 32'hFFFF_FFFF, 32'd1, 1, 4'd0, 0, 0);        // R2 carry, zero
    apply(4'h4, 32'h7FFF_FFFF, 32'd1, 1, 4'd1, 0, 0);        // R2 overflow
    apply(4'hB, 32'h8000_0000, 32'h8000_0000, 0, 4'd15, 0, 0);// R10 CMN
    apply(4'h5, 32'hFFFF_FFFF, 32'd0, 1, 4'd2, 1, 0);        // R3 late carry
    apply(4'h5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 4'd2, 1, 0);
    apply(4'h2, 32'd5, 32'd5, 1, 4'd3, 0, 0);                // R4 equal
    apply(4'h2, 32'd0, 32'd1, 1, 4'd3, 0, 0);                // R4 borrow
    apply(4'hA, 32'h8000_0000, 32'd1, 0, 4'd0, 0, 1);        // R10 CMP
    apply(4'h6, 32'h1234_5678, 32'hFFFF_FFFF, 1, 4'd4, 0, 0);// R5 wrap
    apply(4'h6, 32'd7, 32'd7, 1, 4'd4, 1, 0);                // R5
    apply(4'h3, 32'd1, 32'd9, 1, 4'd5, 0, 0);                // R6 RSB
    apply(4'h7, 32'd9, 32'd1, 1, 4'd5, 0, 0);                // R6 RSC
    apply(4'hF, 32'd0, 32'd0, 1, 4'd6, 0, 1);                // R7 MVN
    apply(4'hE, 32'hF0F0_F0F0, 32'hFF00_FF00, 1, 4'd6, 1, 0);
    apply(4'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 4'd15, 0, 1); // R9 pc dest
    apply(4'h4, 32'd1, 32'd2, 1, 4'd15, 0, 0);               // R9 pc dest
    apply(4'h8, 32'h0F, 32'hF0, 0, 4'd15, 0, 1);             // R10 TST
    apply(4'h9, 32'h55, 32'h55, 0, 4'd0, 1, 0);              // R10 TEQ
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = 32'h8000_0000;
      apply(4'(i % 16), ra, rb, $urandom % 4 != 0,
            (i % 5 == 0) ? 4'd15 : 4'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule